// File: doc/BRIEF.md
# Fixed-Point Fractional-Coefficient FIR Filter

This block is a six-tap direct-form FIR filter. Its input samples are 8-bit two's-complement integers. Its coefficients are real numbers quantised to a 10-bit signed word with six fractional bits, so the representable range is -8 to 7+63/64. Each coefficient word is the real tap multiplied by 64 and rounded. The default taps 1.42, 2.05, -3.23, 4.71, -3.11 and -5.10 become 91, 131, -207, 301, -199 and -326, and negative words are stored in two's complement.

When `valid_i` is high, the filter takes one sample per clock. It multiplies the new sample and the five samples accepted before it by their coefficients and registers the sum. A product of two fixed-point operands has a width equal to the sum of the operand widths. Its binary point is the sum of the two binary points, which here is 8+10 bits with the point at 6.

The output width is derived at elaboration from the worst case: 128 multiplied by the sum of the absolute coefficient words. With the default taps this bound is 160640, so the output is 19-bit signed with six fractional bits. The output stays at full precision. Scaling it back to integer range is left to the consumer.

Top module: `fir_bp_filter`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `y_o` is 0. Reset also clears the sample history, so the first output after reset only sees zeros in the older taps.
- R2: `valid_o` is 1 in exactly those cycles that directly follow a clock edge where `valid_i` was 1.
- R3: On each accepted sample the registered output equals the sum over k=0..5 of c[k]·x[n-k]. Here x[n] is the newest accepted sample, x[n-k] is the sample accepted k acceptances earlier, and c = {91, 131, -207, 301, -199, -326} is in units of 1/64.
- R4: The history advances only on accepted samples. A sample presented with `valid_i` low never enters the taps, and idle cycles do not shift the taps.
- R5: `y_o` is a 19-bit two's-complement word. It holds the exact sum for every input pattern, including full-scale patterns built from -128 and +127, and its magnitude never exceeds 160640.
- R6: A unit impulse (a single 1 followed by zeros) produces the coefficient words 91, 131, -207, 301, -199, -326 on successive outputs. This confirms the 10-bit two's-complement storage of the negative taps. The output after those six is 0.
- R7: When `valid_o` is low, `y_o` holds the last value it was loaded with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe; the sample is accepted on the rising clock edge |
| sample_i | input | 8 | Signed integer input sample |
| valid_o | output | 1 | High for one cycle per accepted sample |
| y_o | output | 19 | Signed filter output with six fractional bits |

## Verification
The bound checker tests a group of properties on every clock:
- the one-cycle relation between the input strobe and the output strobe;
- the hold of the output value while the output strobe is low;
- the worst-case magnitude bound on the output;
- the reset state.

The arithmetic needs the bench's scenarios against a reference sum. Those scenarios are the impulse response, the full-scale sign patterns, the samples offered while the strobe is low, and the clearing of history by a mid-run reset.

// File: rtl/fir_bp_pkg.sv
package fir_bp_pkg;

  localparam int FLAT_W = 1024;  // widest coefficient vector the bound function accepts

  // Worst-case |output|: full-scale negative input times sum of |coefficient words|.
  function automatic longint acc_bound(input logic [FLAT_W-1:0] flat,
                                       input int n, input int cw, input int xw);
    longint sum;
    longint v;
    logic [63:0] raw;
    sum = 0;
    for (int k = 0; k < n; k++) begin
      raw = 64'(flat >> (k * cw)) & ((64'd1 << cw) - 64'd1);
      if (raw[cw-1]) v = longint'(raw) - (longint'(1) << cw);
      else           v = longint'(raw);
      sum += (v < 0) ? -v : v;
    end
    return sum << (xw - 1);
  endfunction

endpackage

// File: rtl/fir_bp_delay.sv
module fir_bp_delay #(
  parameter int X_W   = 8,
  parameter int DEPTH = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      shift_i,
  input  logic [X_W-1:0]            din_i,
  output logic [DEPTH-1:0][X_W-1:0] taps_o
);

  logic [DEPTH-1:0][X_W-1:0] stage_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [X_W-1:0] stage_d;
    if (s == 0) begin : g_head
      assign stage_d = din_i;
    end else begin : g_body
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[s] <= '0;
      else if (shift_i) stage_q[s] <= stage_d;
    end
  end

  assign taps_o = stage_q;

endmodule

// File: rtl/fir_bp_mac.sv
module fir_bp_mac #(
  parameter int                      N_TAPS = 6,
  parameter int                      X_W    = 8,
  parameter int                      C_W    = 10,
  parameter int                      Y_W    = 19,
  parameter logic [N_TAPS*C_W-1:0]   COEFS  = '0
) (
  input  logic [N_TAPS-1:0][X_W-1:0] x_i,
  output logic signed [Y_W-1:0]      sum_o
);

  // Product format: width X_W+C_W, binary point = input bp (0) + coefficient bp.
  localparam int P_W = X_W + C_W;

  logic signed [N_TAPS-1:0][P_W-1:0] prod;

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    localparam logic signed [C_W-1:0] CK = COEFS[k*C_W +: C_W];
    logic signed [P_W-1:0] p;
    assign p       = $signed(x_i[k]) * CK;
    assign prod[k] = p;
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N_TAPS; k++) begin
      sum_o = sum_o + Y_W'($signed(prod[k]));
    end
  end

endmodule

// File: rtl/fir_bp_outreg.sv
module fir_bp_outreg #(
  parameter int Y_W = 19
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic signed [Y_W-1:0] d_i,
  output logic        [Y_W-1:0] y_o,
  output logic                  valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) y_o <= d_i;
    end
  end

endmodule

// File: rtl/fir_bp_filter.sv
module fir_bp_filter
  import fir_bp_pkg::*;
#(
  parameter int N_TAPS = 6,
  parameter int X_W    = 8,
  parameter int C_W    = 10,
  parameter int C_BP   = 6,
  // tap k occupies bits [k*C_W +: C_W]; default taps scaled by 2**C_BP
  parameter logic [N_TAPS*C_W-1:0] COEFS = {10'b1010111010, 10'b1100111001,
                                            10'b0100101101, 10'b1100110001,
                                            10'b0010000011, 10'b0001011011},
  localparam longint ACC_MAX = acc_bound(FLAT_W'(COEFS), N_TAPS, C_W, X_W),
  localparam int     Y_W     = $clog2(ACC_MAX) + 1,
  localparam int     Y_BP    = C_BP
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [X_W-1:0] sample_i,
  output logic           valid_o,
  output logic [Y_W-1:0] y_o
);

  localparam int DEPTH = N_TAPS - 1;

  logic [DEPTH-1:0][X_W-1:0]  hist;
  logic [N_TAPS-1:0][X_W-1:0] x_vec;
  logic signed [Y_W-1:0]      sum;

  fir_bp_delay #(.X_W(X_W), .DEPTH(DEPTH)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_i),
    .din_i   (sample_i),
    .taps_o  (hist)
  );

  for (genvar k = 0; k < N_TAPS; k++) begin : g_xvec
    if (k == 0) begin : g_new
      assign x_vec[k] = sample_i;
    end else begin : g_old
      assign x_vec[k] = hist[k-1];
    end
  end

  fir_bp_mac #(
    .N_TAPS (N_TAPS),
    .X_W    (X_W),
    .C_W    (C_W),
    .Y_W    (Y_W),
    .COEFS  (COEFS)
  ) u_mac (
    .x_i   (x_vec),
    .sum_o (sum)
  );

  fir_bp_outreg #(.Y_W(Y_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (valid_i),
    .d_i     (sum),
    .y_o     (y_o),
    .valid_o (valid_o)
  );

endmodule

// File: rtl/fir_bp_filter_chk.sv
module fir_bp_filter_chk #(
  parameter int     Y_W     = 19,
  parameter longint ACC_MAX = 160640
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           valid_o,
  input logic [Y_W-1:0] y_o
);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= valid_i;
  end

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && y_o == '0));

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == seen_q);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'($signed(y_o)) <= ACC_MAX) && (longint'($signed(y_o)) >= -ACC_MAX));

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o));

endmodule

bind fir_bp_filter fir_bp_filter_chk #(.Y_W(Y_W), .ACC_MAX(ACC_MAX)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .y_o     (y_o)
);

// File: tb/fir_bp_filter_tb_top.sv
`timescale 1ns/1ps
module fir_bp_filter_tb_top;

  localparam int NT = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  sample_i = '0;
  logic        valid_o;
  logic [18:0] y_o;

  int n_chk  = 0;
  int n_fail = 0;
  int hist [NT];
  int last_y = 0;
  const int taps [NT] = '{91, 131, -207, 301, -199, -326};

  always #4 clk_i = ~clk_i;

  fir_bp_filter dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sample_i (sample_i),
    .valid_o  (valid_o),
    .y_o      (y_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_sum();
    int s = 0;
    for (int k = 0; k < NT; k++) s += taps[k] * hist[k];
    return s;
  endfunction

  function automatic int y_val();
    return int'($signed(y_o));
  endfunction

  // Called at a negedge; returns at the following negedge after checking.
  task automatic push(input bit v, input int x, input string req);
    valid_i  = v;
    sample_i = 8'(x);
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    if (v) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      last_y = ref_sum();
      chk({req, " valid_o"}, int'(valid_o), 1);
    end else begin
      chk({req, " R2 idle valid_o"}, int'(valid_o), 0);
    end
    chk({req, " y_o"}, y_val(), last_y);
  endtask

  task automatic clear_model();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    last_y = 0;
  endtask

  initial begin
    int imp [NT] = '{91, 131, -207, 301, -199, -326};
    void'($urandom(32'd20240611));
    clear_model();
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid_o", int'(valid_o), 0);
    chk("R1 reset y_o", y_val(), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 impulse response
    for (int k = 0; k < NT; k++) begin
      push(1'b1, (k == 0) ? 1 : 0, "R3");
      chk("R6 impulse", y_val(), imp[k]);
    end
    push(1'b1, 0, "R6 tail");

    // R4/R7: samples offered with valid low must be ignored
    push(1'b1, 5, "R3");
    push(1'b0, 127, "R7");
    push(1'b0, -128, "R7");
    push(1'b0, 77, "R4");
    push(1'b1, -3, "R4 history unshifted");
    push(1'b1, 0, "R4");

    // R5 full-scale: extreme positive sum, then extreme negative sum
    for (int k = NT - 1; k >= 0; k--) push(1'b1, (taps[k] > 0) ? 127 : -128, "R5");
    chk("R5 max positive", y_val(), 160117);
    for (int k = NT - 1; k >= 0; k--) push(1'b1, (taps[k] > 0) ? -128 : 127, "R5");
    chk("R5 max negative", y_val(), -159908);
    for (int k = 0; k < NT; k++) push(1'b1, -128, "R5 all min");
    for (int k = 0; k < NT; k++) push(1'b1, 127, "R5 all max");

    // R3 random stream with random gaps
    for (int i = 0; i < 400; i++) begin
      bit v = ($urandom % 4) != 0;
      push(v, int'($signed(8'($urandom))), "R3 random");
    end

    // R1 mid-run reset clears history
    push(1'b1, 100, "R3");
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 mid reset valid_o", int'(valid_o), 0);
    chk("R1 mid reset y_o", y_val(), 0);
    rst_ni = 1'b1;
    clear_model();
    @(negedge clk_i);
    push(1'b1, 2, "R1 history cleared");
    chk("R1 after reset", y_val(), 182);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule